// File: doc/BRIEF.md
# Serial Channel FIFO Control with Receive Trigger Interrupt

This block sits beside the serial shifters of one channel. It holds the channel's transmit and receive byte queues, 16 entries each by default, and the byte-wide control register that governs them. Software writes that register to turn on FIFO operation, select DMA mode, pick a receive interrupt threshold and request a flush of either queue. Each flush request acts only when the FIFO enable bit is also 1 in the same write. The request bits are never stored and always read back as 0.

Each queue is run by a three-state machine. The states are FS_EMPTY, FS_PART and FS_FULL. The transitions are:
- EMPTY→PART on an accepted push.
- PART→FULL on a push alone at level DEPTH-1.
- PART→EMPTY on a pop alone at level 1.
- FULL→PART on a pop.
- Any state→EMPTY on a flush, which takes priority over a push or pop in the same cycle.

The machine supplies the empty and full flags. A counter holds the exact level. The receive interrupt is a compare of the receive level against a threshold of 1, 4, 8 or 14 characters. The queues run whatever the enable bit holds; that bit only gates the flushes.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the control register reads 0x00. Both levels are 0, both empty flags are 1, both full and overrun flags are 0, both read-data outputs are 0 and the receive interrupt is 0.
- R2: A control write stores bit 0 (FIFO enable), bit 3 (DMA mode) and bits 7:6 (trigger code), and these bits read back as written. Bits 5:4, 2 and 1 always read 0.
- R3: A write with bits 0 and 2 both 1 empties the transmit queue at that clock edge and clears its overrun flag. A transmit push or pop in the same cycle is ignored, and the receive queue is untouched.
- R4: A write with bits 0 and 1 both 1 empties the receive queue in the same way.
- R5: When bit 0 of a write is 0, bits 1 and 2 of that write change neither queue.
- R6: Bytes leave a queue in the order they entered. A pop updates the read-data output one clock after the pop is sampled.
- R7: A push into a full queue is dropped, including when a pop comes in the same cycle. It leaves the level at DEPTH and sets that queue's overrun flag, which holds until a flush.
- R8: A pop from an empty queue leaves the read-data output and the level unchanged.
- R9: Trigger codes 00, 01, 10 and 11 select thresholds of 1, 4, 8 and 14. The receive interrupt is 1 whenever the receive level is at or above the selected threshold.
- R10: The receive interrupt falls in the cycle in which a pop brings the receive level below the threshold.
- R11: The empty flag equals (level == 0), the full flag equals (level == DEPTH), and the level never exceeds DEPTH.
- R12: A push and a pop in the same cycle on a queue that is neither empty nor full keep its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register readback |
| fifo_en | output | 1 | Stored FIFO enable bit |
| dma_mode | output | 1 | Stored DMA mode bit |
| tx_push | input | 1 | Write a byte into the transmit queue |
| tx_push_data | input | DATA_W | Byte to write into the transmit queue |
| tx_pop | input | 1 | Take a byte out of the transmit queue |
| tx_pop_data | output | DATA_W | Last byte taken from the transmit queue |
| tx_level | output | LVL_W | Transmit queue fill level |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_overrun | output | 1 | Sticky flag: a push to the full transmit queue was dropped |
| rx_push | input | 1 | Write a byte into the receive queue |
| rx_push_data | input | DATA_W | Byte to write into the receive queue |
| rx_pop | input | 1 | Take a byte out of the receive queue |
| rx_pop_data | output | DATA_W | Last byte taken from the receive queue |
| rx_level | output | LVL_W | Receive queue fill level |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_overrun | output | 1 | Sticky flag: a push to the full receive queue was dropped |
| rx_irq | output | 1 | Receive level at or above the threshold |

## Verification
The bench builds the block with its default values: DEPTH of 16 and DATA_W of 8. With these, the largest threshold of 14 sits two entries below a full queue, so the bench can test every trigger code. It can also drive a queue through every state of its machine, including the drop of a push at full and the wrap of both pointers. With a byte width of 8, each pushed value can be distinct, so ordering and stale-data faults show up in the read-data output.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_PART  = 2'd1,
        FS_FULL  = 2'd2
    } fifo_st_e;

    localparam int unsigned EN_BIT    = 0;
    localparam int unsigned RXRST_BIT = 1;
    localparam int unsigned TXRST_BIT = 2;
    localparam int unsigned DMA_BIT   = 3;
    localparam int unsigned TRIG_LSB  = 6;

    function automatic logic [4:0] trig_threshold(input logic [1:0] code);
        logic [4:0] thr;
        case (code)
            2'b00:   thr = 5'd1;
            2'b01:   thr = 5'd4;
            2'b10:   thr = 5'd8;
            default: thr = 5'd14;
        endcase
        return thr;
    endfunction

endpackage

// File: rtl/ufc_byte_fifo.sv
module ufc_byte_fifo
    import ufc_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [LVL_W-1:0]  level,
    output logic              empty,
    output logic              full,
    output logic              overrun
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    fifo_st_e          st, st_nxt;
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && (st != FS_FULL) && !flush;
    assign do_pop  = pop  && (st != FS_EMPTY) && !flush;

    // next-state logic
    always_comb begin
        st_nxt = st;
        if (flush) begin
            st_nxt = FS_EMPTY;
        end else begin
            unique case (st)
                FS_EMPTY: if (do_push) st_nxt = FS_PART;
                FS_PART: begin
                    if (do_push && !do_pop && level == LVL_W'(DEPTH - 1))
                        st_nxt = FS_FULL;
                    else if (do_pop && !do_push && level == LVL_W'(1))
                        st_nxt = FS_EMPTY;
                end
                FS_FULL:  if (do_pop) st_nxt = FS_PART;
                default:  st_nxt = FS_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FS_EMPTY;
        else        st <= st_nxt;
    end

    // outputs
    always_comb begin
        empty = (st == FS_EMPTY);
        full  = (st == FS_FULL);
    end

    // pointers, level, overrun, read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            overrun  <= 1'b0;
            pop_data <= '0;
        end else if (flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level   <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop) begin
                rd_ptr   <= ptr_inc(rd_ptr);
                pop_data <= mem[rd_ptr];
            end
            if (do_push && !do_pop)      level <= level + LVL_W'(1);
            else if (do_pop && !do_push) level <= level - LVL_W'(1);
            if (push && st == FS_FULL)   overrun <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/ufc_ctrl_reg.sv
module ufc_ctrl_reg
    import ufc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       fifo_en,
    output logic       dma_mode,
    output logic [1:0] trig_code,
    output logic       tx_flush,
    output logic       rx_flush
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_en   <= 1'b0;
            dma_mode  <= 1'b0;
            trig_code <= 2'b00;
        end else if (we) begin
            fifo_en   <= wdata[EN_BIT];
            dma_mode  <= wdata[DMA_BIT];
            trig_code <= wdata[TRIG_LSB +: 2];
        end
    end

    // flush strobes act in the write cycle only; never stored
    assign tx_flush = we && wdata[EN_BIT] && wdata[TXRST_BIT];
    assign rx_flush = we && wdata[EN_BIT] && wdata[RXRST_BIT];

    always_comb begin
        rdata                 = '0;
        rdata[EN_BIT]         = fifo_en;
        rdata[DMA_BIT]        = dma_mode;
        rdata[TRIG_LSB +: 2]  = trig_code;
    end

endmodule

// File: rtl/ufc_rx_trigger.sv
module ufc_rx_trigger
    import ufc_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic [LVL_W-1:0] level,
    input  logic [1:0]       trig_code,
    output logic             irq
);
    always_comb begin
        irq = (32'(level) >= 32'(trig_threshold(trig_code)));
    end
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
    import ufc_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic              fifo_en,
    output logic              dma_mode,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_push_data,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_pop_data,
    output logic [LVL_W-1:0]  tx_level,
    output logic              tx_empty,
    output logic              tx_full,
    output logic              tx_overrun,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_push_data,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_pop_data,
    output logic [LVL_W-1:0]  rx_level,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              rx_overrun,
    output logic              rx_irq
);
    logic [1:0] trig_code;
    logic       tx_flush, rx_flush;

    ufc_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .fifo_en   (fifo_en),
        .dma_mode  (dma_mode),
        .trig_code (trig_code),
        .tx_flush  (tx_flush),
        .rx_flush  (rx_flush)
    );

    ufc_byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (tx_push),
        .push_data (tx_push_data),
        .pop       (tx_pop),
        .pop_data  (tx_pop_data),
        .level     (tx_level),
        .empty     (tx_empty),
        .full      (tx_full),
        .overrun   (tx_overrun)
    );

    ufc_byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (rx_push),
        .push_data (rx_push_data),
        .pop       (rx_pop),
        .pop_data  (rx_pop_data),
        .level     (rx_level),
        .empty     (rx_empty),
        .full      (rx_full),
        .overrun   (rx_overrun)
    );

    ufc_rx_trigger #(.LVL_W(LVL_W)) u_trig (
        .level     (rx_level),
        .trig_code (trig_code),
        .irq       (rx_irq)
    );

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [7:0]        cfg_wdata,
    input logic [7:0]        cfg_rdata,
    input logic              tx_push,
    input logic              tx_pop,
    input logic [LVL_W-1:0]  tx_level,
    input logic              tx_empty,
    input logic              tx_full,
    input logic              tx_overrun,
    input logic              rx_push,
    input logic              rx_pop,
    input logic [DATA_W-1:0] rx_pop_data,
    input logic [LVL_W-1:0]  rx_level,
    input logic              rx_empty,
    input logic              rx_irq
);
    logic [LVL_W:0] rx_thr;
    always_comb begin
        unique case (cfg_rdata[7:6])
            2'b00: rx_thr = (LVL_W+1)'(1);
            2'b01: rx_thr = (LVL_W+1)'(4);
            2'b10: rx_thr = (LVL_W+1)'(8);
            2'b11: rx_thr = (LVL_W+1)'(14);
        endcase
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[5:4] == 2'b00 && cfg_rdata[2:1] == 2'b00); // R2

    AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_wdata[0] && cfg_wdata[2] |=> tx_level == '0 && !tx_overrun); // R3

    AST_NO_GATED_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !cfg_wdata[0] && !tx_push && !tx_pop |=> $stable(tx_level)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full && tx_push && !(cfg_we && cfg_wdata[0] && cfg_wdata[2]) |=> tx_overrun); // R7

    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty && rx_pop && !rx_push && !cfg_we |=> $stable(rx_pop_data)); // R8

    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq && rx_pop && !rx_push && !cfg_we && {1'b0, rx_level} == rx_thr |=> !rx_irq); // R10

    AST_FLAGS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty == (tx_level == '0)) && (tx_full == (tx_level == LVL_W'(DEPTH)))
        && (rx_empty == (rx_level == '0))); // R11

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tx_level) <= DEPTH && 32'(rx_level) <= DEPTH); // R11

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/uart_fifo_ctrl_tb.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_tb;
    localparam int DEPTH  = 16;
    localparam int DATA_W = 8;
    localparam int LVL_W  = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic fifo_en, dma_mode;
    logic tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [DATA_W-1:0] tx_push_data = '0, rx_push_data = '0;
    logic [DATA_W-1:0] tx_pop_data, rx_pop_data;
    logic [LVL_W-1:0] tx_level, rx_level;
    logic tx_empty, tx_full, tx_overrun, rx_empty, rx_full, rx_overrun, rx_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_fifo_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (.*);

    typedef struct packed {
        logic       cw;
        logic [7:0] cd;
        logic       pu;
        logic [7:0] pd;
        logic       po;
        logic [4:0] lvl;
        logic       irq;
        logic       dchk;
        logic [7:0] dat;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h41, 1'b0, 8'h00, 1'b0, 5'd0, 1'b0, 1'b0, 8'h00}, // trig 01
        '{1'b0, 8'h00, 1'b1, 8'hA0, 1'b0, 5'd1, 1'b0, 1'b0, 8'h00},
        '{1'b0, 8'h00, 1'b1, 8'hA1, 1'b0, 5'd2, 1'b0, 1'b0, 8'h00},
        '{1'b0, 8'h00, 1'b1, 8'hA2, 1'b0, 5'd3, 1'b0, 1'b0, 8'h00},
        '{1'b0, 8'h00, 1'b1, 8'hA3, 1'b0, 5'd4, 1'b1, 1'b0, 8'h00}, // reach 4
        '{1'b0, 8'h00, 1'b1, 8'hA4, 1'b1, 5'd4, 1'b1, 1'b1, 8'hA0}, // push+pop
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 5'd3, 1'b0, 1'b1, 8'hA1}, // drop below
        '{1'b1, 8'h01, 1'b0, 8'h00, 1'b0, 5'd3, 1'b1, 1'b0, 8'h00}, // trig 00
        '{1'b1, 8'hC1, 1'b0, 8'h00, 1'b0, 5'd3, 1'b0, 1'b0, 8'h00}, // trig 11
        '{1'b1, 8'h83, 1'b0, 8'h00, 1'b0, 5'd0, 1'b0, 1'b0, 8'h00}, // rx flush
        '{1'b1, 8'h82, 1'b1, 8'hB0, 1'b0, 5'd1, 1'b0, 1'b0, 8'h00}, // gated off
        '{1'b1, 8'h81, 1'b1, 8'hB1, 1'b0, 5'd2, 1'b0, 1'b0, 8'h00}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic op(input logic cw, input logic [7:0] cd,
                      input logic tpu, input logic [7:0] tpd, input logic tpo,
                      input logic rpu, input logic [7:0] rpd, input logic rpo);
        cfg_we = cw; cfg_wdata = cd;
        tx_push = tpu; tx_push_data = tpd; tx_pop = tpo;
        rx_push = rpu; rx_push_data = rpd; rx_pop = rpo;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cfg_rdata", cfg_rdata, 8'h00);
        chk("R1 tx_level", tx_level, 0);
        chk("R1 rx_level", rx_level, 0);
        chk("R1 empties", {tx_empty, rx_empty}, 2'b11);
        chk("R1 fulls/overruns", {tx_full, rx_full, tx_overrun, rx_overrun}, 0);
        chk("R1 rx_irq", rx_irq, 0);
        chk("R1 pop data", {tx_pop_data, rx_pop_data}, 0);

        // vector table on the receive queue (R4 R5 R6 R9 R10 R12)
        for (int i = 0; i < NV; i++) begin
            op(VECS[i].cw, VECS[i].cd, 1'b0, 8'h00, 1'b0,
               VECS[i].pu, VECS[i].pd, VECS[i].po);
            chk($sformatf("R9/R10/R12 vec%0d rx_level", i), rx_level, VECS[i].lvl);
            chk($sformatf("R9/R10 vec%0d rx_irq", i), rx_irq, VECS[i].irq);
            if (VECS[i].dchk)
                chk($sformatf("R6 vec%0d rx_pop_data", i), rx_pop_data, VECS[i].dat);
        end

        // R2 readback; write also flushes both queues (R4)
        op(1'b1, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R2 readback FF", cfg_rdata, 8'hC9);
        chk("R2 dma_mode", dma_mode, 1);
        chk("R4 rx flushed", rx_level, 0);

        // R3 transmit flush
        op(1'b1, 8'h01, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
        for (int i = 0; i < 3; i++) op(1'b0, 8'h00, 1'b1, 8'(8'h10 + i), 1'b0, 1'b1, 8'(8'h50 + i), 1'b0);
        op(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1);
        chk("R3 tx level before", tx_level, 3);
        op(1'b1, 8'h05, 1'b1, 8'h77, 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R3 tx level after flush", tx_level, 0);
        chk("R3 tx_empty", tx_empty, 1);
        chk("R3 rx untouched", rx_level, 2);
        chk("R3 bit2 reads 0", cfg_rdata, 8'h01);

        // R5 gated reset bits
        op(1'b0, 8'h00, 1'b1, 8'h20, 1'b0, 1'b0, 8'h00, 1'b0);
        op(1'b0, 8'h00, 1'b1, 8'h21, 1'b0, 1'b0, 8'h00, 1'b0);
        op(1'b1, 8'h06, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R5 tx kept", tx_level, 2);
        chk("R5 rx kept", rx_level, 2);
        chk("R5 fifo_en stored 0", fifo_en, 0);
        op(1'b1, 8'h07, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R3/R4 both flushed", {27'b0, tx_level} + {27'b0, rx_level}, 0);

        // R6 R7 R11 R12 R8 on the transmit queue
        for (int i = 0; i < DEPTH; i++) op(1'b0, 8'h00, 1'b1, 8'(8'h30 + i), 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R11 tx_full", tx_full, 1);
        chk("R11 tx_level full", tx_level, DEPTH);
        chk("R7 no overrun yet", tx_overrun, 0);
        op(1'b0, 8'h00, 1'b1, 8'h99, 1'b1, 1'b0, 8'h00, 1'b0);
        chk("R7 push+pop at full: level", tx_level, DEPTH - 1);
        chk("R7 overrun set", tx_overrun, 1);
        chk("R6 first out", tx_pop_data, 8'h30);
        op(1'b0, 8'h00, 1'b1, 8'h77, 1'b1, 1'b0, 8'h00, 1'b0);
        chk("R12 level kept", tx_level, DEPTH - 1);
        chk("R6 second out", tx_pop_data, 8'h31);
        for (int i = 0; i < DEPTH - 1; i++) op(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
        chk("R6 last out", tx_pop_data, 8'h77);
        chk("R11 tx_empty", tx_empty, 1);
        op(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
        chk("R8 data held", tx_pop_data, 8'h77);
        chk("R8 level held", tx_level, 0);
        chk("R7 overrun sticky", tx_overrun, 1);
        op(1'b1, 8'h05, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
        chk("R7 overrun cleared by flush", tx_overrun, 0);

        // R9 code 10 -> threshold 8
        op(1'b1, 8'h81, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
        for (int i = 0; i < 7; i++) op(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 8'(i), 1'b0);
        chk("R9 level 7 thr 8", rx_irq, 0);
        op(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 8'h07, 1'b0);
        chk("R9 level 8 thr 8", rx_irq, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule